// File: doc/BRIEF.md
# Timer-based input pulse stretcher

The block watches one synchronous digital input and produces one output pulse per accepted input pulse. Every output edge after the first one is placed by an equality match between a free-running 16-bit tick counter and a compare register. The compare register is loaded either from a value captured off the same counter when an input edge is seen, or from its own previous value. Because capture and compare share one time base, every offset is simply a sum modulo the counter width.

There are two modes, chosen by `mode_fixed_i` when the input rising edge is accepted. In extend mode the output goes high one clock after the rising edge is sampled. On the falling edge, the capture register takes the count and the compare register is loaded with that capture plus `delta_i`. The output drops on the match, so the output is `delta_i` ticks wider than the input. In fixed-width mode the rising edge arms a compare at the capture plus a short lead, so that the match is never already in the past. That match raises the output and reloads the compare with itself plus `width_i`. The next match lowers the output, whatever the input width. The edge detector tracks whether it is waiting for a rising or a falling edge and returns to rising after each falling capture. Input edges are ignored while an output pulse is still in progress.

Top module: `pulse_stretcher`

## Requirements
- R1: In extend mode (`mode_fixed_i`=0 at the rising edge), `pulse_o` is high in the clock after the clock edge that first samples `pulse_i` high.
- R2: In extend mode, `pulse_o` falls `delta_i` ticks after the edge that samples `pulse_i` low, so the output stays high for the input width plus `delta_i` clocks (`delta_i` >= 1, sampled at the falling edge).
- R3: In fixed-width mode (`mode_fixed_i`=1 at the rising edge), `pulse_o` rises LEAD_TICKS clocks after the rising edge is sampled and stays high for exactly `width_i` clocks (`width_i` >= 1), independent of when the input falls.
- R4: `cmp_evt_o` is high for one clock on each compare match that changes `pulse_o`, in the same clock as the change: once per extend pulse and twice per fixed-width pulse.
- R5: Input rising or falling edges seen while a pulse is in progress are ignored. An input that is still high when the pulse ends starts no new pulse.
- R6: Compare sums wrap modulo 2^16, so a delay whose end lies past the counter wrap still ends exactly `delta_i` ticks after the falling edge.
- R7: `busy_o` rises together with the acceptance of the rising edge and falls in the same clock that `pulse_o` falls for the last time.
- R8: After reset, `pulse_o`, `busy_o` and `cmp_evt_o` are all low.
- R9: After a falling-edge capture, the edge detector waits for a rising edge again, so a new pulse started right after the previous one ends is handled in full.
- R10: The mode is taken only at the accepted rising edge. Changing `mode_fixed_i` during a pulse does not alter that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one counter tick per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 1 | Input pulse, synchronous to clk_i |
| mode_fixed_i | input | 1 | 1 = fixed-width mode, 0 = extend mode |
| delta_i | input | CNT_W | Extension added after the input falling edge, in ticks |
| width_i | input | CNT_W | Output width in fixed-width mode, in ticks |
| pulse_o | output | 1 | Stretched output pulse |
| busy_o | output | 1 | A pulse is in progress |
| cmp_evt_o | output | 1 | One-clock strobe on each compare match that moves pulse_o |

## Verification
On every cycle the assertions check the following: the event strobe coincides with an output transition; the output is never high without busy; no edge disturbs the delay tail before its match; the output stays low during the fixed-mode lead; the edge tracker returns to rising after a falling capture; and the counter passes from all-ones to zero. Only the directed scenarios can show exact latencies and widths in both modes, the number of strobes per pulse, and the handling of edges that arrive during a pulse. The same holds for a mode change in mid-pulse, back-to-back pulses and a delay that crosses the counter wrap.

// File: rtl/pstr_pkg.sv
package pstr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for rising edge
    ST_HOLD,   // extend: output high, waiting for falling edge
    ST_TAIL,   // extend: waiting for delta match
    ST_LEAD,   // fixed: waiting for rising-edge match
    ST_FIXED   // fixed: waiting for width match
  } pstr_state_e;
endpackage

// File: rtl/pstr_counter.sv
module pstr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + 1'b1;
  end

  // R6: time base wraps through zero
  a_r6_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_o) == {CNT_W{1'b1}}) |-> (cnt_o == '0));
endmodule

// File: rtl/pstr_capture.sv
module pstr_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic             arm_i,
  input  logic             rise_only_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             hit_o,
  output logic [CNT_W-1:0] cap_o
);
  logic             pulse_q;
  logic             wait_fall_q;
  logic [CNT_W-1:0] cap_q;
  logic             rose, fell;

  assign rose  = pulse_i & ~pulse_q;
  assign fell  = ~pulse_i & pulse_q;
  assign hit_o = arm_i & (wait_fall_q ? fell : rose);
  // forward the value being captured this edge
  assign cap_o = hit_o ? cnt_i : cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q     <= 1'b0;
      wait_fall_q <= 1'b0;
      cap_q       <= '0;
    end else begin
      pulse_q <= pulse_i;
      if (hit_o) begin
        cap_q       <= cnt_i;
        wait_fall_q <= rise_only_i ? 1'b0 : ~wait_fall_q;
      end
    end
  end

  // R9: after a falling capture the detector waits for rising again
  a_r9_back_to_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && wait_fall_q) |=> !wait_fall_q);
endmodule

// File: rtl/pstr_compare.sv
module pstr_compare #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             from_prev_i,
  input  logic [CNT_W-1:0] base_i,
  input  logic [CNT_W-1:0] off_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             match_o
);
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] sum;

  // single adder, modulo 2^CNT_W
  assign sum     = (from_prev_i ? cmp_q : base_i) + off_i;
  assign match_o = (cnt_i == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmp_q <= '0;
    else if (load_i) cmp_q <= sum;
  end
endmodule

// File: rtl/pulse_stretcher.sv
module pulse_stretcher
  import pstr_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int LEAD_TICKS = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic             mode_fixed_i,
  input  logic [CNT_W-1:0] delta_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             pulse_o,
  output logic             busy_o,
  output logic             cmp_evt_o
);
  localparam logic [CNT_W-1:0] LEAD_V = CNT_W'(LEAD_TICKS);

  pstr_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt, cap;
  logic             hit, match, arm, rise_only;
  logic             pulse_d, evt_d;
  logic             cmp_ld, cmp_prev;
  logic [CNT_W-1:0] cmp_off;

  assign arm       = (state_q == ST_IDLE) || (state_q == ST_HOLD);
  assign rise_only = (state_q == ST_IDLE) && mode_fixed_i;
  assign busy_o    = (state_q != ST_IDLE);

  pstr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt)
  );

  pstr_capture #(.CNT_W(CNT_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pulse_i    (pulse_i),
    .arm_i      (arm),
    .rise_only_i(rise_only),
    .cnt_i      (cnt),
    .hit_o      (hit),
    .cap_o      (cap)
  );

  pstr_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cmp_ld),
    .from_prev_i(cmp_prev),
    .base_i     (cap),
    .off_i      (cmp_off),
    .cnt_i      (cnt),
    .match_o    (match)
  );

  always_comb begin
    state_d  = state_q;
    pulse_d  = pulse_o;
    evt_d    = 1'b0;
    cmp_ld   = 1'b0;
    cmp_prev = 1'b0;
    cmp_off  = LEAD_V;
    unique case (state_q)
      ST_IDLE: if (hit) begin
        if (mode_fixed_i) begin
          cmp_ld  = 1'b1;
          state_d = ST_LEAD;
        end else begin
          pulse_d = 1'b1;
          state_d = ST_HOLD;
        end
      end
      ST_HOLD: if (hit) begin
        cmp_ld  = 1'b1;
        cmp_off = delta_i;
        state_d = ST_TAIL;
      end
      ST_TAIL: if (match) begin
        pulse_d = 1'b0;
        evt_d   = 1'b1;
        state_d = ST_IDLE;
      end
      ST_LEAD: if (match) begin
        pulse_d  = 1'b1;
        evt_d    = 1'b1;
        cmp_ld   = 1'b1;
        cmp_prev = 1'b1;
        cmp_off  = width_i;
        state_d  = ST_FIXED;
      end
      ST_FIXED: if (match) begin
        pulse_d = 1'b0;
        evt_d   = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pulse_o   <= 1'b0;
      cmp_evt_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      pulse_o   <= pulse_d;
      cmp_evt_o <= evt_d;
    end
  end

  // R4: strobe marks an output transition
  a_r4_evt_marks_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_evt_o |-> (pulse_o != $past(pulse_o)));

  // R7: output never high outside busy
  a_r7_busy_covers_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> busy_o);

  // R5: nothing but the match ends the delay tail
  a_r5_tail_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TAIL && !match) |=> (state_q == ST_TAIL && pulse_o));

  // R3: output stays low during the lead phase
  a_r3_lead_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LEAD) |-> !pulse_o);
endmodule

// File: tb/pulse_stretcher_bench.sv
`timescale 1ns/1ps
module pulse_stretcher_bench;
  localparam int CNT_W = 16;
  localparam int LEAD  = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pulse = 1'b0;
  logic             mode_fixed = 1'b0;
  logic [CNT_W-1:0] delta = '0;
  logic [CNT_W-1:0] width = '0;
  logic             pulse_o, busy_o, cmp_evt_o;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, n_rise = 0, evt_n = 0;
  int t_rise = 0, t_fall = 0, t_brise = 0, t_bfall = 0;
  logic prev_o = 1'b0, prev_b = 1'b0;

  always #10 clk = ~clk;

  pulse_stretcher #(.CNT_W(CNT_W), .LEAD_TICKS(LEAD)) u_pulse_stretcher (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pulse_i     (pulse),
    .mode_fixed_i(mode_fixed),
    .delta_i     (delta),
    .width_i     (width),
    .pulse_o     (pulse_o),
    .busy_o      (busy_o),
    .cmp_evt_o   (cmp_evt_o)
  );

  // monitor, samples away from the active edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (pulse_o && !prev_o) begin n_rise = n_rise + 1; t_rise = cyc; end
    if (!pulse_o && prev_o) t_fall = cyc;
    if (busy_o && !prev_b) t_brise = cyc;
    if (!busy_o && prev_b) t_bfall = cyc;
    if (cmp_evt_o) evt_n = evt_n + 1;
    prev_o = pulse_o;
    prev_b = busy_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic clr();
    n_rise = 0;
    evt_n  = 0;
  endtask

  task automatic wait_done();
    int k = 0;
    while ((busy_o || pulse_o) && k < 70000) begin
      step(1);
      k++;
    end
    chk("done", int'(k < 70000), 1);
    step(2);
  endtask

  task automatic t_reset();
    chk("R8 pulse_o", int'(pulse_o), 0);
    chk("R8 busy_o", int'(busy_o), 0);
    chk("R8 cmp_evt_o", int'(cmp_evt_o), 0);
  endtask

  // extend: input high w cycles, extension d
  task automatic t_extend(input int w, input int d, input string tag);
    int c;
    mode_fixed = 1'b0;
    delta = CNT_W'(d);
    clr();
    c = cyc;
    pulse = 1'b1;
    step(w);
    pulse = 1'b0;
    wait_done();
    chk({tag, " R1 latency"}, t_rise - c, 2);
    chk({tag, " R2 width"}, t_fall - t_rise, w + d);
    chk({tag, " R4 strobes"}, evt_n, 1);
    chk({tag, " R7 busy rise"}, t_brise, t_rise);
    chk({tag, " R7 busy fall"}, t_bfall, t_fall);
    chk({tag, " R5 single pulse"}, n_rise, 1);
  endtask

  task automatic t_fixed(input int w, input int wd, input string tag);
    int c;
    mode_fixed = 1'b1;
    width = CNT_W'(wd);
    clr();
    c = cyc;
    pulse = 1'b1;
    step(w);
    pulse = 1'b0;
    wait_done();
    chk({tag, " R3 latency"}, t_rise - c, 2 + LEAD);
    chk({tag, " R3 width"}, t_fall - t_rise, wd);
    chk({tag, " R4 strobes"}, evt_n, 2);
    chk({tag, " R7 busy rise"}, t_brise - c, 2);
    chk({tag, " R7 busy fall"}, t_bfall, t_fall);
    chk({tag, " R5 single pulse"}, n_rise, 1);
    mode_fixed = 1'b0;
  endtask

  // R5: edges during the tail and an input held high past the end
  task automatic t_ignore();
    int c;
    mode_fixed = 1'b0;
    delta = CNT_W'(30);
    clr();
    c = cyc;
    pulse = 1'b1; step(5);
    pulse = 1'b0; step(8);
    pulse = 1'b1; step(4);
    pulse = 1'b0; step(3);
    pulse = 1'b1; step(40);
    pulse = 1'b0;
    wait_done();
    step(5);
    chk("R5 rises", n_rise, 1);
    chk("R5 width", t_fall - t_rise, 35);
    chk("R5 latency", t_rise - c, 2);
    chk("R5 strobes", evt_n, 1);
    chk("R5 output low after", int'(pulse_o), 0);
  endtask

  // R10: mode change during the pulse
  task automatic t_mode_latch();
    mode_fixed = 1'b0;
    delta = CNT_W'(12);
    width = CNT_W'(3);
    clr();
    pulse = 1'b1; step(3);
    mode_fixed = 1'b1; step(5);
    pulse = 1'b0;
    wait_done();
    chk("R10 width", t_fall - t_rise, 20);
    chk("R10 strobes", evt_n, 1);
    mode_fixed = 1'b0;
  endtask

  // R9: second pulse right after the first ends
  task automatic t_rearm();
    int c;
    mode_fixed = 1'b0;
    delta = CNT_W'(6);
    clr();
    pulse = 1'b1; step(4);
    pulse = 1'b0;
    while (busy_o) step(1);
    c = cyc;
    delta = CNT_W'(9);
    pulse = 1'b1; step(7);
    pulse = 1'b0;
    wait_done();
    chk("R9 rises", n_rise, 2);
    chk("R9 second latency", t_rise - c, 2);
    chk("R9 second width", t_fall - t_rise, 16);
    chk("R9 strobes", evt_n, 2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    #35 rst_n = 1'b1;
    step(2);
    t_reset();
    t_extend(10, 25, "ext_a");
    t_extend(3, 1, "ext_min");
    t_fixed(4, 20, "fix_short");
    t_fixed(40, 12, "fix_long");
    t_fixed(2, 1, "fix_min");
    t_ignore();
    t_mode_latch();
    t_rearm();
    step(1000);
    t_extend(6, 65000, "R6 wrap");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule